// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software by counting cycles of a slow always-on clock. A 3-bit period code selects an expiry time of a power-of-two number of ticks. A 2-bit window code selects how much of the end of that interval is open for a restart. Software restarts the count by writing a fixed key byte to the trigger register while the window is open. Any other write to the trigger register raises a reset request at once: a wrong value, or the key written while the window is closed.

When the count runs out, the block raises a one-cycle reset request toward the chip's reset controller, and it counts again from zero. The option inputs are meant to be static. One combination of them is illegal. While that combination is selected, the block flags a configuration error, holds the reset request high and keeps the counter at zero. The block has no pause input, so counting goes on during flash programming and every other mode.

Top module: `wwdt_core`

## Requirements
- R1: Period code n (0 to 7) on `ovf_sel_i` makes the timer expire 2^(10+n) clock edges after reset release or after the last restart. `rst_req_o` goes high right after that edge. There is no input that pauses the count.
- R2: An expiry request lasts exactly one cycle. The counter is zero in that cycle, so the next expiry follows one full period later unless a write intervenes.
- R3: A write of 0xAC with the window open sets the count to zero. No request is raised, and the next expiry comes one full period after the write edge.
- R4: Let P be the period. The window is open when the count just before the write edge is at least P − (k+1)·P/4, where k is the value of `win_sel_i`. Code 3 therefore leaves the window open for the whole period.
- R5: A write of 0xAC while the window is closed raises `rst_req_o` in the cycle after the write edge, and the counter restarts from zero.
- R6: A write of any value other than 0xAC raises `rst_req_o` in the cycle after the write edge, whatever the window state. The counter restarts from zero.
- R7: While `ovf_sel_i` = 0 and `win_sel_i` = 0, `cfg_err_o` and `rst_req_o` stay high combinationally and the counter is held at zero. Counting starts from zero once a legal code is selected.
- R8: While `rd_en_i` is high, `rd_data_o` is 0x9A. Otherwise it is 0. A read never changes the count or the expiry time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Low-speed counting clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the trigger register |
| wr_data_i | input | 8 | Write data for the trigger register |
| rd_en_i | input | 1 | Read strobe for the trigger register |
| rd_data_o | output | 8 | Read data, fixed pattern |
| ovf_sel_i | input | 3 | Period code, static |
| win_sel_i | input | 2 | Window code, static |
| rst_req_o | output | 1 | Reset request to the reset controller |
| cfg_err_o | output | 1 | Illegal option combination selected |

## Verification
A write on edge c+1 shows its effect on `rst_req_o` after that same edge. A bad write raises the request in cycle c+1. A good restart moves the next expiry to cycle c+1+P. Reset released before edge r+1 expires in cycle r+P. The read data and the illegal-combination flag are combinational and are sampled one time step after the inputs change. The driver computes each due cycle from its own model of the count and queues it. The monitor samples at the falling edge and pops an item exactly in its due cycle. Any request outside a due cycle is reported as a failure.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  localparam int unsigned MIN_EXP = 10;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned WIN_W   = 2;
  localparam int unsigned DATA_W  = 8;
  localparam logic [7:0]  KEY_VAL = 8'hAC;
  localparam logic [7:0]  RD_VAL  = 8'h9A;
endpackage

// File: rtl/wwdt_period_dec.sv
module wwdt_period_dec #(
  parameter int unsigned MIN_EXP = 10,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned WIN_W   = 2,
  parameter int unsigned CNT_W   = MIN_EXP + (1 << SEL_W)
) (
  input  logic [SEL_W-1:0] ovf_sel_i,
  input  logic [WIN_W-1:0] win_sel_i,
  output logic [CNT_W-1:0] last_o,
  output logic [CNT_W-1:0] win_start_o,
  output logic             cfg_err_o
);
  localparam int unsigned NSEL = 1 << SEL_W;

  logic [CNT_W-1:0] per_tab [NSEL];
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] step;
  logic [CNT_W-1:0] open_len;

  for (genvar g = 0; g < NSEL; g++) begin : g_per
    assign per_tab[g] = CNT_W'(1) << (MIN_EXP + g);
  end

  always_comb begin
    period      = per_tab[ovf_sel_i];
    step        = period >> WIN_W;
    open_len    = step * (CNT_W'(win_sel_i) + CNT_W'(1));
    last_o      = period - CNT_W'(1);
    win_start_o = period - open_len;
    cfg_err_o   = (ovf_sel_i == '0) && (win_sel_i == '0);
  end
endmodule

// File: rtl/wwdt_trigger.sv
module wwdt_trigger #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CNT_W   = 18,
  parameter logic [7:0]  KEY_VAL = 8'hAC
) (
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  win_start_i,
  input  logic              block_i,
  output logic              kick_o,
  output logic              viol_o
);
  logic key_ok;
  logic win_open;

  always_comb begin
    key_ok   = (wr_data_i == DATA_W'(KEY_VAL));
    win_open = (cnt_i >= win_start_i);
    kick_o   = wr_en_i && !block_i && key_ok && win_open;
    viol_o   = wr_en_i && !block_i && !(key_ok && win_open);
  end
endmodule

// File: rtl/wwdt_counter.sv
module wwdt_counter #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] last_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  // >= guards against a period code lowered while running
  assign wrap  = (cnt_q >= last_i);
  assign ovf_o = wrap && !clear_i && !hold_i;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (hold_i || clear_i || wrap) cnt_q <= '0;
    else                                cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/wwdt_core.sv
module wwdt_core #(
  parameter int unsigned MIN_EXP = wwdt_pkg::MIN_EXP,
  parameter int unsigned SEL_W   = wwdt_pkg::SEL_W,
  parameter int unsigned WIN_W   = wwdt_pkg::WIN_W,
  parameter int unsigned DATA_W  = wwdt_pkg::DATA_W,
  parameter logic [7:0]  KEY_VAL = wwdt_pkg::KEY_VAL,
  parameter logic [7:0]  RD_VAL  = wwdt_pkg::RD_VAL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [SEL_W-1:0]  ovf_sel_i,
  input  logic [WIN_W-1:0]  win_sel_i,
  output logic              rst_req_o,
  output logic              cfg_err_o
);
  localparam int unsigned CNT_W = MIN_EXP + (1 << SEL_W);

  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] win_start;
  logic [CNT_W-1:0] cnt_q;
  logic             cfg_err;
  logic             kick;
  logic             viol;
  logic             ovf;
  logic             req_q;

  wwdt_period_dec #(
    .MIN_EXP(MIN_EXP), .SEL_W(SEL_W), .WIN_W(WIN_W), .CNT_W(CNT_W)
  ) u_dec (
    .ovf_sel_i  (ovf_sel_i),
    .win_sel_i  (win_sel_i),
    .last_o     (last),
    .win_start_o(win_start),
    .cfg_err_o  (cfg_err)
  );

  wwdt_trigger #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .KEY_VAL(KEY_VAL)
  ) u_trig (
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .cnt_i      (cnt_q),
    .win_start_i(win_start),
    .block_i    (cfg_err),
    .kick_o     (kick),
    .viol_o     (viol)
  );

  wwdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (cfg_err),
    .clear_i(kick || viol),
    .last_i (last),
    .cnt_o  (cnt_q),
    .ovf_o  (ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= !cfg_err && (viol || ovf);
  end

  assign rst_req_o = req_q || cfg_err;
  assign cfg_err_o = cfg_err;
  assign rd_data_o = rd_en_i ? DATA_W'(RD_VAL) : '0;
endmodule

// File: rtl/wwdt_checker.sv
module wwdt_checker #(
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned WIN_W   = 2,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CNT_W   = 18,
  parameter logic [7:0]  KEY_VAL = 8'hAC,
  parameter logic [7:0]  RD_VAL  = 8'h9A
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [SEL_W-1:0]  ovf_sel_i,
  input logic [WIN_W-1:0]  win_sel_i,
  input logic              rst_req_o,
  input logic              cfg_err_o,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  last_i,
  input logic [CNT_W-1:0]  win_start_i
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= last_i);  // R1

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && !cfg_err_o && !wr_en_i) |=> (!rst_req_o || cfg_err_o));  // R2

  AST_CLOSED_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i == DATA_W'(KEY_VAL) && cnt_i < win_start_i && !cfg_err_o)
      |=> rst_req_o);  // R5

  AST_BAD_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i != DATA_W'(KEY_VAL) && !cfg_err_o) |=> rst_req_o);  // R6

  AST_CFG_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_sel_i == '0 && win_sel_i == '0) |-> (cfg_err_o && rst_req_o));  // R7

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> (cnt_i == '0));  // R7

  AST_READ_VAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> (rd_data_o == DATA_W'(RD_VAL)));  // R8
endmodule

bind wwdt_core wwdt_checker #(
  .SEL_W(SEL_W), .WIN_W(WIN_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
  .KEY_VAL(KEY_VAL), .RD_VAL(RD_VAL)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_en_i    (rd_en_i),
  .rd_data_o  (rd_data_o),
  .ovf_sel_i  (ovf_sel_i),
  .win_sel_i  (win_sel_i),
  .rst_req_o  (rst_req_o),
  .cfg_err_o  (cfg_err_o),
  .cnt_i      (cnt_q),
  .last_i     (last),
  .win_start_i(win_start)
);

// File: tb/wwdt_core_bench.sv
module wwdt_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 200000;

  typedef struct {
    int    cyc;
    string tag;
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       rd_en_i = 1'b0;
  logic [7:0] rd_data_o;
  logic [2:0] ovf_sel_i = 3'd0;
  logic [1:0] win_sel_i = 2'd1;
  logic       rst_req_o;
  logic       cfg_err_o;

  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   z = 0;
  int   per = 1024;
  int   win = 1;
  bit   mon_en = 1'b0;
  bit   done = 1'b0;
  exp_t q[$];

  wwdt_core u_wwdt_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .ovf_sel_i(ovf_sel_i),
    .win_sel_i(win_sel_i), .rst_req_o(rst_req_o), .cfg_err_o(cfg_err_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(input int c, input string tag);
    exp_t e;
    e.cyc = c;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: pops each expected request in its due cycle
  always @(negedge clk_i) begin
    if (mon_en) begin
      if (q.size() > 0 && q[0].cyc == cyc) begin
        chk(rst_req_o == 1'b1, q[0].tag, int'(rst_req_o), 1);
        void'(q.pop_front());
      end else if (rst_req_o) begin
        chk(1'b0, "R2 (unexpected request)", 1, 0);
      end
    end
  end

  task automatic do_reset(input int sel, input int w);
    @(negedge clk_i); #1;
    mon_en = 1'b0;
    rst_ni = 1'b0;
    ovf_sel_i = 3'(sel);
    win_sel_i = 2'(w);
    per = 1024 << sel;
    win = w;
    q.delete();
    repeat (3) @(negedge clk_i);
    #1;
    rst_ni = 1'b1;
    z = cyc;
    mon_en = 1'b1;
  endtask

  task automatic wait_cnt(input int n);
    @(negedge clk_i);
    forever begin
      while (cyc - z >= per) z += per;
      if (cyc - z == n) break;
      @(negedge clk_i);
    end
    #1;
  endtask

  task automatic kick(input logic [7:0] d, input int n, input string tag_ok, input string tag_bad);
    int c;
    int start;
    bit open;
    wait_cnt(n);
    c = cyc;
    start = per - (per / 4) * (win + 1);
    open = (c - z) >= start;
    wr_en_i = 1'b1;
    wr_data_i = d;
    q.delete();
    if (d == 8'hAC && open) begin
      z = c + 1;
      push(z + per, tag_ok);
    end else begin
      push(c + 1, tag_bad);
      z = c + 1;
      push(z + per, "R2");
    end
    @(negedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  initial begin
    int d;
    // reset state
    repeat (2) @(negedge clk_i);
    chk(rst_req_o == 1'b0, "R2 reset req", int'(rst_req_o), 0);
    chk(cfg_err_o == 1'b0, "R7 reset err", int'(cfg_err_o), 0);
    chk(rd_data_o == 8'h00, "R8 idle read", int'(rd_data_o), 0);

    // R1/R2: free-running expiries, read has no effect
    do_reset(0, 1);
    push(z + 1024, "R1");
    push(z + 2048, "R2");
    wait_cnt(100);
    rd_en_i = 1'b1;
    #1 chk(rd_data_o == 8'h9A, "R8 read value", int'(rd_data_o), 8'h9A);
    @(negedge clk_i); #1;
    rd_en_i = 1'b0;
    #1 chk(rd_data_o == 8'h00, "R8 read idle", int'(rd_data_o), 0);
    wait_cnt(1023);
    wait_cnt(1023);

    // R3..R6 with a 50% window (opens at 512)
    kick(8'hAC, 600, "R3", "R3");
    kick(8'hAC, 511, "R5", "R5");
    kick(8'hAC, 512, "R4", "R4");
    kick(8'h55, 800, "R6", "R6");
    wait_cnt(1023);
    wait_cnt(5);

    // R4: 25% window, P=2048, opens at 1536
    do_reset(1, 0);
    kick(8'hAC, 1535, "R4", "R4");
    kick(8'hAC, 1536, "R4", "R4");
    wait_cnt(2047);
    wait_cnt(5);

    // R4: full window, early restart allowed; R6 bad key there too
    do_reset(0, 3);
    kick(8'hAC, 1, "R4", "R4");
    kick(8'h00, 3, "R6", "R6");
    wait_cnt(1023);
    wait_cnt(5);

    // R1: longer period code
    do_reset(3, 2);
    push(z + 8192, "R1");
    wait_cnt(8191);
    wait_cnt(3);

    // R7: prohibited combination
    do_reset(0, 1);
    wait_cnt(50);
    mon_en = 1'b0;
    win_sel_i = 2'd0;
    #1 chk(cfg_err_o && rst_req_o, "R7 err now", int'({cfg_err_o, rst_req_o}), 3);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk(cfg_err_o && rst_req_o, "R7 err held", int'({cfg_err_o, rst_req_o}), 3);
    end
    #1;
    win_sel_i = 2'd1;
    #1 chk(rst_req_o == 1'b0, "R7 err clear", int'(rst_req_o), 0);
    d = cyc;
    q.delete();
    push(d + 1024, "R7");
    z = d;
    mon_en = 1'b1;
    wait_cnt(1023);
    wait_cnt(3);

    chk(q.size() == 0, "R1 queue drained", q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule